// File: doc/BRIEF.md
# Eight-Pin GPIO Port Register Bank

This block is the register core of a general-purpose I/O port. A serial front end presents a 2-bit register index, write data and a write strobe. The block keeps four byte-wide registers: a read-only view of the pins, an output latch, a polarity mask and a direction mask. It returns the contents of the selected register on a registered read bus. Toward the pads it drives one output enable and one output value per pin, and it samples the pin levels through a synchronizer.

The pads are modelled as ideal tri-state signals. The pad drives `pin_out` when `pin_oe` is high, and `pin_in` always carries the level seen on the pin. A synchronous active-high reset stands in for power-on reset. After reset every pin is an input.

Top module: `pio_regbank`

## Requirements
- R1: The register index selects the input view (0), the output latch (1), the polarity mask (2) or the direction mask (3). A strobed write to index 1, 2 or 3 stores the data byte. `rd_data` shows the selected register one cycle after it is selected.
- R2: A strobed write to index 0 changes no register. The output latch, the polarity mask and the direction mask all keep their values.
- R3: The input view reports the level on every pin, whatever that pin's direction. A pin that the block drives reads back its own driven level.
- R4: The input view is the stored pin sample XORed with the polarity mask. A mask bit of 1 inverts that bit and a mask bit of 0 passes it unchanged.
- R5: A direction bit of 1 makes the pin an input (`pin_oe` low). A direction bit of 0 makes the pin an output (`pin_oe` high). `pin_oe` follows the direction mask one cycle after the mask changes.
- R6: An output latch bit has no effect on a pin set as an input. For such a pin, `pin_out` is 0 and `pin_oe` is 0.
- R7: Reading index 1 returns the stored latch value, not the level on the pin.
- R8: Reset sets the output latch to 0xFF, the polarity mask to 0x00 and the direction mask to 0xFF. After reset `pin_oe` is 0x00.
- R9: A pin change with index 0 selected first shows on `rd_data` at the fourth rising edge after the change. It does not show at the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe for the indexed register |
| reg_sel | input | 2 | Register index for both write and read |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Registered read data of the selected register |
| pin_in | input | 8 | Levels seen on the pins |
| pin_oe | output | 8 | Per-pin driver enable, high means driven |
| pin_out | output | 8 | Per-pin driven value |

## Verification
The embedded properties check these rules on every cycle:
- the reset values of the three writable registers;
- that index-0 writes leave those registers stable;
- that a direction write lands;
- that `pin_oe` tracks the direction mask one cycle later;
- that an undriven pin never carries a high `pin_out`;
- that read data for indices 0 and 1 matches the polarity-corrected pin sample and the latch.

Only the bench scenarios can show behaviour that needs the external pin model:
- inputs reflecting pins that the block itself drives;
- the output latch reading back a value that differs from the pin;
- the exact four-edge synchronizer latency.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_IN  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_OUT = 2'd1;
  localparam logic [SEL_W-1:0] SEL_POL = 2'd2;
  localparam logic [SEL_W-1:0] SEL_DIR = 2'd3;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '1;
        else     stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '1;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     out_q,
  output logic [W-1:0]     pol_q,
  output logic [W-1:0]     dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '1;
      pol_q <= '0;
      dir_q <= '1;
    end else if (wr_stb) begin
      case (wr_sel)
        SEL_OUT: out_q <= wr_data;
        SEL_POL: pol_q <= wr_data;
        SEL_DIR: dir_q <= wr_data;
        default: ;
      endcase
    end
  end

  AST_RESET_DEFAULTS: assert property (@(posedge clk)
    rst |=> (out_q == '1 && pol_q == '0 && dir_q == '1)); // R8

  AST_IN_WRITE_DISCARDED: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_sel == SEL_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q))); // R2

  AST_DIR_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_sel == SEL_DIR) |=> (dir_q == $past(wr_data))); // R1
endmodule

// File: rtl/pio_drive.sv
module pio_drive #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] dir_q,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe  <= '0;
      pin_out <= '0;
    end else begin
      pin_oe  <= ~dir_q;
      pin_out <= out_q & ~dir_q;
    end
  end

  AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pin_oe == ~$past(dir_q))); // R5

  AST_INPUT_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == '0); // R6
endmodule

// File: rtl/pio_read_mux.sv
module pio_read_mux
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     in_q,
  input  logic [W-1:0]     out_q,
  input  logic [W-1:0]     pol_q,
  input  logic [W-1:0]     dir_q,
  output logic [W-1:0]     rd_q
);
  logic [W-1:0] rd_next;

  always_comb begin
    case (sel)
      SEL_IN:  rd_next = in_q ^ pol_q;
      SEL_OUT: rd_next = out_q;
      SEL_POL: rd_next = pol_q;
      SEL_DIR: rd_next = dir_q;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_next;
  end

  AST_IN_READBACK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel) == SEL_IN) |-> (rd_q == ($past(in_q) ^ $past(pol_q)))); // R4

  AST_OUT_READBACK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel) == SEL_OUT) |-> (rd_q == $past(out_q))); // R7
endmodule

// File: rtl/pio_regbank.sv
module pio_regbank
  import pio_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     rd_data,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     pin_oe,
  output logic [W-1:0]     pin_out
);
  logic [W-1:0] pin_sync;
  logic [W-1:0] in_q;
  logic [W-1:0] out_q;
  logic [W-1:0] pol_q;
  logic [W-1:0] dir_q;

  pio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  // Input view register: the capture point for the pin sample.
  always_ff @(posedge clk) begin
    if (rst) in_q <= '1;
    else     in_q <= pin_sync;
  end

  pio_cfg_regs #(.W(W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .wr_sel  (reg_sel),
    .wr_data (wr_data),
    .out_q   (out_q),
    .pol_q   (pol_q),
    .dir_q   (dir_q)
  );

  pio_drive #(.W(W)) u_drive (
    .clk     (clk),
    .rst     (rst),
    .out_q   (out_q),
    .dir_q   (dir_q),
    .pin_oe  (pin_oe),
    .pin_out (pin_out)
  );

  pio_read_mux #(.W(W)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .sel   (reg_sel),
    .in_q  (in_q),
    .out_q (out_q),
    .pol_q (pol_q),
    .dir_q (dir_q),
    .rd_q  (rd_data)
  );
endmodule

// File: tb/pio_regbank_test.sv
`timescale 1ns/1ps
module pio_regbank_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [7:0] ext = 8'hFF;
  logic [7:0] pin_oe, pin_out;
  wire  [7:0] pins = (pin_oe & pin_out) | (~pin_oe & ext);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pio_regbank uut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .pin_in(pins),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );

  // Vector fields: req[30:27] idx[26:25] wr[24] wdata[23:16] ext[15:8] exp[7:0]
  localparam int NV = 12;
  localparam logic [30:0] VEC [NV] = '{
    {4'd3, 2'd0, 1'b0, 8'h00, 8'hA5, 8'hA5},  // R3 all inputs
    {4'd1, 2'd2, 1'b1, 8'h0F, 8'hA5, 8'h0F},  // R1 polarity write
    {4'd4, 2'd0, 1'b0, 8'h00, 8'hA5, 8'hAA},  // R4 low nibble inverted
    {4'd7, 2'd1, 1'b1, 8'h3C, 8'h5A, 8'h3C},  // R7 latch, not pins
    {4'd1, 2'd3, 1'b1, 8'hF0, 8'h5A, 8'hF0},  // R1 direction write
    {4'd4, 2'd0, 1'b0, 8'h00, 8'hFF, 8'hF3},  // R4 mixed pins, inverted
    {4'd1, 2'd2, 1'b1, 8'h00, 8'hFF, 8'h00},  // R1 clear polarity
    {4'd3, 2'd0, 1'b0, 8'h00, 8'h00, 8'h0C},  // R3 driven nibble reads back
    {4'd1, 2'd3, 1'b1, 8'h00, 8'h00, 8'h00},  // R1 all outputs
    {4'd3, 2'd0, 1'b0, 8'h00, 8'hFF, 8'h3C},  // R3 driven pins override ext
    {4'd7, 2'd1, 1'b1, 8'h81, 8'hFF, 8'h81},  // R7 new latch value
    {4'd3, 2'd0, 1'b0, 8'h00, 8'h00, 8'h81}   // R3 pins follow latch
  };

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [7:0] d);
    @(negedge clk);
    reg_sel = idx; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [7:0] v);
    @(negedge clk);
    reg_sel = idx;
    repeat (6) @(negedge clk);
    v = rd_data;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    chk("R8 pin_oe", pin_oe, 8'h00);
    rd(2'd1, v); chk("R8 out", v, 8'hFF);
    rd(2'd2, v); chk("R8 pol", v, 8'h00);
    rd(2'd3, v); chk("R8 dir", v, 8'hFF);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ext = VEC[i][15:8];
      reg_sel = VEC[i][26:25];
      if (VEC[i][24]) begin
        wr_data = VEC[i][23:16];
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
      end
      repeat (6) @(negedge clk);
      chk($sformatf("R%0d vector %0d", VEC[i][30:27], i), rd_data, VEC[i][7:0]);
    end

    // R2: index-0 write is discarded
    wr(2'd0, 8'h5A);
    rd(2'd1, v); chk("R2 out kept", v, 8'h81);
    rd(2'd2, v); chk("R2 pol kept", v, 8'h00);
    rd(2'd3, v); chk("R2 dir kept", v, 8'h00);

    // R5 / R6: mixed direction, drive observed at the pins
    wr(2'd1, 8'hFF);
    @(negedge clk);
    reg_sel = 2'd3; wr_data = 8'h55; wr_stb = 1'b1;
    @(negedge clk);  // direction stored at the edge before this point
    wr_stb = 1'b0;
    @(negedge clk);  // one edge later the enables follow
    chk("R5 pin_oe", pin_oe, 8'hAA);
    chk("R6 pin_out", pin_out, 8'hAA);

    // R9: synchronizer latency, all pins inputs, no inversion
    wr(2'd3, 8'hFF);
    ext = 8'hFF;
    @(negedge clk); reg_sel = 2'd0;
    repeat (8) @(negedge clk);
    chk("R9 settled", rd_data, 8'hFF);
    ext = 8'h00;
    repeat (3) @(negedge clk);
    chk("R9 third edge", rd_data, 8'hFF);
    @(negedge clk);
    chk("R9 fourth edge", rd_data, 8'h00);

    // R8: reset in mid-run restores defaults
    wr(2'd2, 8'h33);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rd(2'd2, v); chk("R8 pol after reset", v, 8'h00);
    rd(2'd3, v); chk("R8 dir after reset", v, 8'hFF);

    done = 1'b1;
    finish_run();
  end
endmodule